// File: doc/BRIEF.md
# Line-Aligned Video Timing FIFO

This block carries 10-bit serial-digital video words from a recovered pixel-clock domain into a read clock domain that the user supplies. Each stored entry holds the video word together with its horizontal, vertical and field timing flags and an ancillary-data flag. Because the flags travel through the same memory as the word, they leave the FIFO in the same read cycle as the word they describe. The FIFO can be used to move data across clock phases and to delay or align it.

The pointers do not run freely. Upstream timing logic pulses a line marker on the write side when the first 000 word of the start-of-active-video sequence (3FF, 000, 000, XYZ) is on the input, and that word is stored at address 0. On the read side, a single-cycle low pulse on an active-low restart input brings the read pointer back to address 0. The next output word is therefore that same sequence word. Every write to address 0 also produces a load pulse, which is carried into the read domain through a toggle synchroniser. That pulse can drive the restart input directly, so the read side locks to the line boundary.

Top module: `vid_line_fifo`

## Requirements
- R1: While reset is held and after its release, all read outputs are 0 and the load pulse is low. The read outputs stay 0 until the first read restart.
- R2: On each write-clock edge with write enable high, the 14-bit entry is stored at the current write address and the write address advances by one. With write enable low, nothing is stored and the write address holds, even when the line marker is high.
- R3: A write with both the line marker and write enable high stores its entry at address 0. The following writes go to addresses 1, 2 and onward.
- R4: A read restart is a read-clock edge that samples the restart input low after the previous edge sampled it high. On the read-clock edge after the restart edge, the outputs present entry 0. Each later edge presents the next entry. A restart in the middle of a stream also returns reading to entry 0.
- R5: The H, V, F and ancillary flags on the read outputs are the flags written with the word shown on the data output in that same cycle.
- R6: Both the write address and the read address wrap from DEPTH-1 to 0. A read that passes address DEPTH-1 continues with entry 0.
- R7: Holding the restart input low for several read cycles causes exactly one restart. Reading continues in sequence through the cycles that are still low.
- R8: Each write to address 0, whether from the line marker or from wrapping, produces exactly one load pulse. That pulse is one read-clock cycle wide and appears within SYNC_STAGES+3 read cycles. This assumes writes to address 0 are at least two write cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered pixel clock (write domain) |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write enable for the current word |
| wr_line_mark | input | 1 | High with the first 000 word of start-of-active-video; stores it at address 0 |
| wr_data | input | DATA_W | Video word to store |
| wr_h | input | 1 | Horizontal timing flag for the word |
| wr_v | input | 1 | Vertical timing flag for the word |
| wr_f | input | 1 | Field flag for the word |
| wr_anc | input | 1 | Ancillary-data flag for the word |
| rd_clk | input | 1 | Externally supplied read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_restart_n | input | 1 | Active-low single-cycle pulse; restarts reading at address 0 |
| rd_data | output | DATA_W | Registered video word |
| rd_h | output | 1 | Horizontal flag aligned to rd_data |
| rd_v | output | 1 | Vertical flag aligned to rd_data |
| rd_f | output | 1 | Field flag aligned to rd_data |
| rd_anc | output | 1 | Ancillary flag aligned to rd_data |
| rd_load | output | 1 | One-read-cycle pulse for each write to address 0 |

## Verification
A restart is sampled at one read edge. The restart detect register changes at that edge, and the output register loads entry 0 at the next edge. The bench therefore samples entry 0 at the second falling read-clock edge after it lowers the restart input, and then compares one new entry at each falling edge after that. A write to address 0 reaches rd_load only after the toggle flop, the synchroniser stages and the edge-detect register. For that reason, load pulses are counted continuously on falling read edges, and the count is compared only after a settling window of twelve read cycles.

// File: rtl/vid_fifo_pkg.sv
// Shared definitions for the line-aligned video FIFO.
// Assumes nothing beyond a 1800-2017 compiler.
package vid_fifo_pkg;

    // Timing and ancillary flags stored beside each video word.
    typedef struct packed {
        logic h;
        logic v;
        logic f;
        logic anc;
    } vid_flags_t;

    localparam int FLAG_W = $bits(vid_flags_t);

endpackage

// File: rtl/vid_fifo_wr_ctrl.sv
// Write-side address control.
// Produces the address for the current word and advances the pointer.
// A line marker forces the address to 0. A write to address 0 raises load_evt.
// Assumes DEPTH >= 2 and AW = $clog2(DEPTH).
module vid_fifo_wr_ctrl #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic          wr_line_mark,
    output logic          wr_we,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] wr_ptr,
    output logic          load_evt
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Pick the address for this word: 0 on a line marker, otherwise the pointer.
    always_comb begin
        wr_we    = wr_en;
        wr_addr  = wr_line_mark ? '0 : wr_ptr;
        load_evt = wr_en && (wr_addr == '0);
    end

    // Advance the pointer past the word just written, wrapping at the depth.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            wr_ptr <= (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
        end
    end

endmodule

// File: rtl/vid_fifo_mem.sv
// Entry storage. The write port is clocked by the write clock.
// The read port is combinational and is registered by the read controller.
// Assumes the reader does not read an address in the same cycle it is written.
module vid_fifo_mem #(
    parameter int W     = 14,
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] ram [DEPTH];

    // Store one entry per enabled write cycle.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            ram[waddr] <= wdata;
        end
    end

    // Present the addressed entry to the read register.
    assign rdata = ram[raddr];

endmodule

// File: rtl/vid_fifo_rd_ctrl.sv
// Read-side control.
// Detects a falling edge on the active-low restart input, registers it,
// and on the next edge loads entry 0 and starts sequential reading.
// The output register stays 0 until the first restart.
// Assumes DEPTH >= 2 and AW = $clog2(DEPTH).
module vid_fifo_rd_ctrl #(
    parameter int W     = 14,
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_restart_n,
    input  logic [W-1:0]  rdata,
    output logic [AW-1:0] raddr,
    output logic [AW-1:0] rd_ptr,
    output logic          rd_run,
    output logic          rd_fall_q,
    output logic [W-1:0]  rd_word
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic restart_prev;

    // Register a falling edge of the restart input (acts on the edge only).
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            restart_prev <= 1'b1;
            rd_fall_q    <= 1'b0;
        end else begin
            restart_prev <= rd_restart_n;
            rd_fall_q    <= restart_prev && !rd_restart_n;
        end
    end

    // Read address: 0 right after a restart, otherwise the running pointer.
    always_comb begin
        raddr = rd_fall_q ? '0 : rd_ptr;
    end

    // Load the output register and step the pointer once reading has begun.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_run  <= 1'b0;
            rd_ptr  <= '0;
            rd_word <= '0;
        end else if (rd_fall_q || rd_run) begin
            rd_run  <= 1'b1;
            rd_word <= rdata;
            rd_ptr  <= (raddr == LAST) ? '0 : raddr + 1'b1;
        end
    end

endmodule

// File: rtl/vid_fifo_pulse_sync.sv
// Carries single-cycle events from the source clock to the destination clock.
// Each source pulse flips a toggle flop. The toggle passes through STAGES
// flops, and an edge detect emits one destination-cycle pulse.
// Assumes source pulses are at least two source cycles apart and STAGES >= 2.
module vid_fifo_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);

    logic              src_tog;
    logic [STAGES-1:0] sync_q;
    logic              seen_q;

    // Flip the toggle once for each source event.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            src_tog <= 1'b0;
        end else if (src_pulse) begin
            src_tog <= ~src_tog;
        end
    end

    // Resynchronise the toggle and turn each change into a one-cycle pulse.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            sync_q    <= '0;
            seen_q    <= 1'b0;
            dst_pulse <= 1'b0;
        end else begin
            sync_q    <= {sync_q[STAGES-2:0], src_tog};
            seen_q    <= sync_q[STAGES-1];
            dst_pulse <= sync_q[STAGES-1] ^ seen_q;
        end
    end

endmodule

// File: rtl/vid_line_fifo.sv
// Line-aligned dual-clock video FIFO.
// Stores a video word plus its H/V/F and ancillary flags in each entry.
// Write and read pointers are re-zeroed at the line marker and at a read
// restart. A load pulse in the read domain marks each write to address 0.
// Assumes DEPTH covers one full line (>= 2048 by default). Assumes the line
// marker is given with the first 000 word of start-of-active-video.
module vid_line_fifo
    import vid_fifo_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int DEPTH       = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic              wr_line_mark,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_h,
    input  logic              wr_v,
    input  logic              wr_f,
    input  logic              wr_anc,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_restart_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_h,
    output logic              rd_v,
    output logic              rd_f,
    output logic              rd_anc,
    output logic              rd_load
);

    localparam int AW      = $clog2(DEPTH);
    localparam int ENTRY_W = DATA_W + FLAG_W;

    vid_flags_t          wr_flags;
    vid_flags_t          rd_flags;
    logic [ENTRY_W-1:0]  wr_entry;
    logic [ENTRY_W-1:0]  rd_entry;
    logic [ENTRY_W-1:0]  mem_rdata;
    logic                wr_we;
    logic [AW-1:0]       wr_addr;
    logic [AW-1:0]       wr_ptr;
    logic                load_evt;
    logic [AW-1:0]       raddr;
    logic [AW-1:0]       rd_ptr;
    logic                rd_run;
    logic                rd_fall_q;

    // Pack the write-side word and flags into one entry.
    always_comb begin
        wr_flags = '{h: wr_h, v: wr_v, f: wr_f, anc: wr_anc};
        wr_entry = {wr_data, wr_flags};
    end

    vid_fifo_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .wr_en       (wr_en),
        .wr_line_mark(wr_line_mark),
        .wr_we       (wr_we),
        .wr_addr     (wr_addr),
        .wr_ptr      (wr_ptr),
        .load_evt    (load_evt)
    );

    vid_fifo_mem #(.W(ENTRY_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk(wr_clk),
        .we    (wr_we),
        .waddr (wr_addr),
        .wdata (wr_entry),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    vid_fifo_rd_ctrl #(.W(ENTRY_W), .DEPTH(DEPTH), .AW(AW)) u_rd (
        .rd_clk      (rd_clk),
        .rd_rst_n    (rd_rst_n),
        .rd_restart_n(rd_restart_n),
        .rdata       (mem_rdata),
        .raddr       (raddr),
        .rd_ptr      (rd_ptr),
        .rd_run      (rd_run),
        .rd_fall_q   (rd_fall_q),
        .rd_word     (rd_entry)
    );

    vid_fifo_pulse_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
        .src_clk  (wr_clk),
        .src_rst_n(wr_rst_n),
        .src_pulse(load_evt),
        .dst_clk  (rd_clk),
        .dst_rst_n(rd_rst_n),
        .dst_pulse(rd_load)
    );

    // Split the registered entry back into word and aligned flags.
    always_comb begin
        rd_data  = rd_entry[ENTRY_W-1:FLAG_W];
        rd_flags = rd_entry[FLAG_W-1:0];
        rd_h     = rd_flags.h;
        rd_v     = rd_flags.v;
        rd_f     = rd_flags.f;
        rd_anc   = rd_flags.anc;
    end

endmodule

// File: rtl/vid_line_fifo_chk.sv
// Assertion checker for vid_line_fifo, attached by bind.
// Watches pointer behaviour on both clocks and the load pulse width.
module vid_line_fifo_chk #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 2048,
    parameter int AW     = 11
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic              wr_line_mark,
    input logic [AW-1:0]     wr_ptr,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_restart_n,
    input logic [AW-1:0]     rd_ptr,
    input logic              rd_run,
    input logic              rd_fall_q,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_h,
    input logic              rd_v,
    input logic              rd_f,
    input logic              rd_anc,
    input logic              rd_load
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // R1: outputs quiet before the first restart
    p_idle_quiet_r1: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_run |-> (rd_data == '0 && !rd_h && !rd_v && !rd_f && !rd_anc));

    // R2: no write, no pointer movement
    p_wr_hold_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_en |=> $stable(wr_ptr));

    // R3: the line marker places its word at 0, so the next address is 1
    p_mark_zero_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_line_mark) |=> (wr_ptr == AW'(1)));

    // R4: a restart edge leads to entry 0 loaded, with the pointer at 1
    p_restart_first_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $fell(rd_restart_n) |=> ##1 (rd_run && rd_ptr == AW'(1)));

    // R6: read pointer wraps at the depth
    p_rd_wrap_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_run && !rd_fall_q && rd_ptr == LAST) |=> (rd_ptr == '0));

    // R7: a restart input that stays low raises no second restart
    p_hold_low_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!rd_restart_n && !$past(rd_restart_n)) |=> !rd_fall_q);

    // R8: the load pulse lasts a single read cycle
    p_load_single_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_load |=> !rd_load);

endmodule

bind vid_line_fifo vid_line_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .wr_en       (wr_en),
    .wr_line_mark(wr_line_mark),
    .wr_ptr      (wr_ptr),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .rd_restart_n(rd_restart_n),
    .rd_ptr      (rd_ptr),
    .rd_run      (rd_run),
    .rd_fall_q   (rd_fall_q),
    .rd_data     (rd_data),
    .rd_h        (rd_h),
    .rd_v        (rd_v),
    .rd_f        (rd_f),
    .rd_anc      (rd_anc),
    .rd_load     (rd_load)
);

// File: tb/vid_line_fifo_test.sv
// Directed bench for vid_line_fifo. There is one task per scenario, and a
// bench-side copy of the memory is built from the requirements.
module vid_line_fifo_test;

    localparam int DATA_W = 10;
    localparam int DEPTH  = 2048;
    localparam int SYNC   = 2;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_line_mark = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_h = 1'b0, wr_v = 1'b0, wr_f = 1'b0, wr_anc = 1'b0;
    logic              rd_restart_n = 1'b1;
    logic [DATA_W-1:0] rd_data;
    logic              rd_h, rd_v, rd_f, rd_anc, rd_load;

    int n_cmp = 0;
    int n_bad = 0;
    int load_seen = 0;
    int load_exp = 0;
    int wp = 0;
    bit done = 1'b0;
    logic load_prev = 1'b0;
    logic [13:0] mdl [DEPTH];

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    vid_line_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC)) uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en),
        .wr_line_mark(wr_line_mark), .wr_data(wr_data),
        .wr_h(wr_h), .wr_v(wr_v), .wr_f(wr_f), .wr_anc(wr_anc),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_restart_n(rd_restart_n),
        .rd_data(rd_data), .rd_h(rd_h), .rd_v(rd_v), .rd_f(rd_f),
        .rd_anc(rd_anc), .rd_load(rd_load)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R8: count load pulses and flag any pulse wider than one read cycle
    always @(negedge rd_clk) begin
        if (rd_load) begin
            load_seen++;
            if (load_prev) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R8: actual 2-cycle load pulse expected 1-cycle");
            end
        end
        load_prev = rd_load;
    end

    function automatic logic [13:0] word_of(int i, int seed);
        logic [9:0] d;
        logic [3:0] fl;
        d  = (i == 0) ? 10'h000 : 10'((seed * 37 + i * 13) & 32'h3ff);
        fl = 4'((i + seed) & 15);
        return {d, fl};
    endfunction

    task automatic push(logic [13:0] e, bit mark);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_line_mark = mark;
        {wr_data, wr_h, wr_v, wr_f, wr_anc} = e;
        if (mark) wp = 0;
        mdl[wp] = e;
        if (wp == 0) load_exp++;
        wp = (wp + 1) % DEPTH;
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        wr_en = 1'b0;
        wr_line_mark = 1'b0;
    endtask

    task automatic write_line(int n, int seed, bit mark_first);
        for (int i = 0; i < n; i++) push(word_of(i, seed), mark_first && i == 0);
        wr_idle();
    endtask

    task automatic check_outputs(string req, logic [13:0] exp);
        check(req, {18'd0, rd_data, rd_h, rd_v, rd_f, rd_anc}, {18'd0, exp});
    endtask

    // R4/R5/R6/R7: restart with the input low for 'hold' cycles, then compare n entries
    task automatic read_check(string req, int n, int hold);
        @(negedge rd_clk);
        rd_restart_n = 1'b0;
        @(negedge rd_clk);
        if (hold <= 1) rd_restart_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge rd_clk);
            check_outputs(req, mdl[k % DEPTH]);
            if (k + 2 >= hold) rd_restart_n = 1'b1;
        end
    endtask

    task automatic check_loads(string req);
        repeat (12) @(negedge rd_clk);
        check(req, 32'(load_seen), 32'(load_exp));
    endtask

    // R1: reset state and quiet outputs before the first restart
    task automatic t_reset();
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (5) @(negedge rd_clk);
        check_outputs("R1 in reset", 14'd0);
        check("R1 load in reset", 32'(rd_load), 32'd0);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        check_outputs("R1 after release", 14'd0);
    endtask

    // R2/R3/R8: one marked line, no reads yet, load pulse counted
    task automatic t_first_line();
        write_line(40, 3, 1'b1);
        check_loads("R8 marker load");
        check_outputs("R1 idle until restart", 14'd0);
    endtask

    // R4/R5: single-cycle restart and aligned flags
    task automatic t_single_restart();
        read_check("R4 R5 single restart", 40, 1);
    endtask

    // R2: disabled writes are ignored even with the marker high
    task automatic t_ignored_writes();
        for (int i = 0; i < 10; i++) begin
            @(negedge wr_clk);
            wr_en = 1'b0;
            wr_line_mark = 1'b1;
            wr_data = 10'h155;
            {wr_h, wr_v, wr_f, wr_anc} = 4'hf;
        end
        wr_idle();
        for (int i = 0; i < 5; i++) push(word_of(100 + i, 9), 1'b0);
        wr_idle();
        check_loads("R2 no load from disabled write");
        read_check("R2 disabled writes ignored", 45, 1);
    endtask

    // R7: restart held low for four cycles
    task automatic t_hold_low();
        read_check("R7 held-low restart", 30, 4);
    endtask

    // R6/R8: a line longer than the depth wraps both pointers
    task automatic t_wrap();
        write_line(DEPTH + 2, 7, 1'b1);
        check_loads("R8 marker and wrap loads");
        read_check("R6 wrap", DEPTH + 3, 1);
    endtask

    initial begin
        t_reset();
        t_first_line();
        t_single_restart();
        t_ignored_writes();
        t_hold_low();
        t_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule